// File: doc/BRIEF.md
# Synchronous Trap Entry Controller

This block accepts a synchronous exception request made of a cause code, a trap value and the program counter of the faulting instruction. In the clock edge that accepts the request it selects the handling privilege level, records the faulting state in that level's trap registers, moves the hart to the new privilege and launches a one-cycle redirect toward the handler base address of that level. It holds the current privilege (user, supervisor or machine), an exception delegation mask, and for the machine and supervisor levels a handler base, a saved PC, a cause register and a trap value register.

A delegation bit indexed by the cause code sends an exception to supervisor level, but only when the hart is currently below machine level. Otherwise the exception is taken in machine mode. A small configuration port loads the delegation mask and the two handler bases. A privilege-set port lets the surrounding core place the hart in a given level. The six trap registers are visible as outputs so that the core can read them.

Top module: `trap_entry`

## Requirements
- R1: After reset the privilege is machine (code 2'b11), `redirValid` is low, and all six trap registers, the delegation mask and both handler bases are zero.
- R2: An exception raised in user (2'b00) or supervisor (2'b01) mode whose delegation bit is clear is taken in machine mode, and `curPriv` becomes 2'b11 one cycle later.
- R3: An exception raised below machine mode whose delegation bit (mask bit number = cause code) is set is taken in supervisor mode, and `curPriv` becomes 2'b01. The trap registers of the level that was not chosen keep their values.
- R4: An exception raised in machine mode is always taken in machine mode, even when its delegation bit is set.
- R5: The saved-PC register of the chosen level receives `excPc`.
- R6: The trap value register of the chosen level receives `excTval`, for example the faulting address of a load access fault (cause code 5).
- R7: The cause register of the chosen level receives the cause code, zero-extended, so its top (interrupt) bit is 0.
- R8: In the cycle after an accepted exception, `redirValid` is high and `redirPc` equals the chosen level's handler base with bits [1:0] cleared. In every cycle that follows a cycle without an exception, `redirValid` is low. Back-to-back exceptions each produce their own redirect.
- R9: A configuration write with `cfgSel` 0 loads the delegation mask, 1 loads the machine handler base, and 2 loads the supervisor handler base.
- R10: A privilege write takes effect on the next edge. A write of the reserved code 2'b10 is ignored. A privilege write in the same cycle as an exception is overridden by the trap's target level.
- R11: An exception uses the delegation mask and handler bases held before any configuration write made in the same cycle. The write still takes effect for later exceptions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception request this cycle |
| excCause | input | CAUSE_W | Exception cause code |
| excTval | input | XLEN | Trap value (e.g. faulting address) |
| excPc | input | XLEN | PC of the faulting instruction |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target: 0 mask, 1 machine base, 2 supervisor base |
| cfgData | input | XLEN | Configuration write data |
| privWrEn | input | 1 | Privilege-set strobe |
| privWrData | input | 2 | Privilege to set |
| curPriv | output | 2 | Current privilege level |
| redirValid | output | 1 | One-cycle redirect pulse |
| redirPc | output | XLEN | Handler address for the redirect |
| mEpc | output | XLEN | Machine saved PC |
| mCause | output | XLEN | Machine cause |
| mTval | output | XLEN | Machine trap value |
| sEpc | output | XLEN | Supervisor saved PC |
| sCause | output | XLEN | Supervisor cause |
| sTval | output | XLEN | Supervisor trap value |

## Verification
The cases that are hardest to reach from the ports are collisions at a single edge. In one, an exception arrives in the same cycle as a handler-base write. In another, it arrives together with a privilege write. In a third, two exceptions come back to back and the first one changes the privilege that decides the delegation of the second. The stimulus drives these collisions on purpose: it starts from user mode with a delegated cause, then rewrites the supervisor base in the same cycle. It also chains a delegated trap from supervisor mode directly into a non-delegated one. A scoreboard compares every redirect against the full expected state of both levels.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } privT;

  typedef enum logic [1:0] {
    CFG_DELEG = 2'd0,
    CFG_MTVEC = 2'd1,
    CFG_STVEC = 2'd2,
    CFG_NONE  = 2'd3
  } cfgSelT;

  localparam int LVL_M   = 0;
  localparam int LVL_S   = 1;
  localparam int NUM_LVL = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic saveM;
    logic saveS;
    logic loadRedir;
    logic useStvec;
  } trapStrobeT;

endpackage

// File: rtl/trap_lvl_bank.sv
module trap_lvl_bank #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               saveEn,
  input  logic [XLEN-1:0]    pcIn,
  input  logic [CAUSE_W-1:0] causeIn,
  input  logic [XLEN-1:0]    tvalIn,
  input  logic               tvecWrEn,
  input  logic [XLEN-1:0]    tvecWrData,
  output logic [XLEN-1:0]    epcQ,
  output logic [XLEN-1:0]    causeQ,
  output logic [XLEN-1:0]    tvalQ,
  output logic [XLEN-1:0]    tvecQ
);

  logic [XLEN-1:0] causeExt;
  assign causeExt = XLEN'(causeIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ   <= '0;
      causeQ <= '0;
      tvalQ  <= '0;
    end else if (saveEn) begin
      epcQ   <= pcIn;
      causeQ <= causeExt;
      tvalQ  <= tvalIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         tvecQ <= '0;
    else if (tvecWrEn) tvecQ <= tvecWrData;
  end

  p_epc_save_r5: assert property (@(posedge clk) disable iff (!rstN)
    saveEn |=> epcQ == $past(pcIn));
  p_tval_save_r6: assert property (@(posedge clk) disable iff (!rstN)
    saveEn |=> tvalQ == $past(tvalIn));
  p_cause_msb_r7: assert property (@(posedge clk) disable iff (!rstN)
    causeQ[XLEN-1] == 1'b0);
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !saveEn |=> ($stable(epcQ) && $stable(causeQ) && $stable(tvalQ)));

endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  trapStrobeT         strobe,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    excTval,
  input  logic [XLEN-1:0]    excPc,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgSel,
  input  logic [XLEN-1:0]    cfgData,
  output logic               delegHit,
  output logic [XLEN-1:0]    redirPc,
  output logic [XLEN-1:0]    mEpc,
  output logic [XLEN-1:0]    mCause,
  output logic [XLEN-1:0]    mTval,
  output logic [XLEN-1:0]    sEpc,
  output logic [XLEN-1:0]    sCause,
  output logic [XLEN-1:0]    sTval
);

  localparam int DELEG_W = 1 << CAUSE_W;

  logic [DELEG_W-1:0] delegMask;
  logic [XLEN-1:0]    epcArr   [NUM_LVL];
  logic [XLEN-1:0]    causeArr [NUM_LVL];
  logic [XLEN-1:0]    tvalArr  [NUM_LVL];
  logic [XLEN-1:0]    tvecArr  [NUM_LVL];
  logic [XLEN-1:0]    baseSel;

  always_ff @(posedge clk) begin
    if (!rstN)
      delegMask <= '0;
    else if (cfgWrEn && cfgSel == CFG_DELEG)
      delegMask <= DELEG_W'(cfgData);
  end

  assign delegHit = delegMask[excCause];

  for (genvar gLvl = 0; gLvl < NUM_LVL; gLvl++) begin : gBank
    logic saveEn;
    logic tvecWr;
    assign saveEn = (gLvl == LVL_S) ? strobe.saveS : strobe.saveM;
    assign tvecWr = cfgWrEn &&
                    (cfgSel == ((gLvl == LVL_S) ? CFG_STVEC : CFG_MTVEC));
    trap_lvl_bank #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_bank (
      .clk       (clk),
      .rstN      (rstN),
      .saveEn    (saveEn),
      .pcIn      (excPc),
      .causeIn   (excCause),
      .tvalIn    (excTval),
      .tvecWrEn  (tvecWr),
      .tvecWrData(cfgData),
      .epcQ      (epcArr[gLvl]),
      .causeQ    (causeArr[gLvl]),
      .tvalQ     (tvalArr[gLvl]),
      .tvecQ     (tvecArr[gLvl])
    );
  end

  assign baseSel = strobe.useStvec ? tvecArr[LVL_S] : tvecArr[LVL_M];

  always_ff @(posedge clk) begin
    if (!rstN)                 redirPc <= '0;
    else if (strobe.loadRedir) redirPc <= {baseSel[XLEN-1:2], 2'b00};
  end

  assign mEpc   = epcArr[LVL_M];
  assign mCause = causeArr[LVL_M];
  assign mTval  = tvalArr[LVL_M];
  assign sEpc   = epcArr[LVL_S];
  assign sCause = causeArr[LVL_S];
  assign sTval  = tvalArr[LVL_S];

  p_redir_m_base_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRedir && !strobe.useStvec) |=>
      redirPc == {$past(tvecArr[LVL_M][XLEN-1:2]), 2'b00});
  p_redir_s_base_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRedir && strobe.useStvec) |=>
      redirPc == {$past(tvecArr[LVL_S][XLEN-1:2]), 2'b00});

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       excValid,
  input  logic       delegHit,
  input  logic       privWrEn,
  input  logic [1:0] privWrData,
  output privT       curPriv,
  output trapStrobeT strobe,
  output logic       redirValid
);

  logic toSuper;
  logic privLegal;

  assign toSuper   = delegHit && (curPriv != PRIV_M);
  assign privLegal = (privWrData != 2'b10);

  always_comb begin
    strobe           = '0;
    strobe.saveS     = excValid && toSuper;
    strobe.saveM     = excValid && !toSuper;
    strobe.loadRedir = excValid;
    strobe.useStvec  = toSuper;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPriv    <= PRIV_M;
      redirValid <= 1'b0;
    end else begin
      redirValid <= excValid;
      if (excValid)
        curPriv <= toSuper ? PRIV_S : PRIV_M;
      else if (privWrEn && privLegal)
        curPriv <= privT'(privWrData);
    end
  end

  p_mach_stays_r4: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && curPriv == PRIV_M) |=> curPriv == PRIV_M);
  p_priv_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    curPriv != 2'b10);
  p_redir_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    !excValid |=> !redirValid);
  p_redir_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> redirValid);

endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    excTval,
  input  logic [XLEN-1:0]    excPc,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgSel,
  input  logic [XLEN-1:0]    cfgData,
  input  logic               privWrEn,
  input  logic [1:0]         privWrData,
  output logic [1:0]         curPriv,
  output logic               redirValid,
  output logic [XLEN-1:0]    redirPc,
  output logic [XLEN-1:0]    mEpc,
  output logic [XLEN-1:0]    mCause,
  output logic [XLEN-1:0]    mTval,
  output logic [XLEN-1:0]    sEpc,
  output logic [XLEN-1:0]    sCause,
  output logic [XLEN-1:0]    sTval
);

  trapStrobeT strobe;
  privT       privQ;
  logic       delegHit;

  trap_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .excValid  (excValid),
    .delegHit  (delegHit),
    .privWrEn  (privWrEn),
    .privWrData(privWrData),
    .curPriv   (privQ),
    .strobe    (strobe),
    .redirValid(redirValid)
  );

  trap_dp #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .excCause(excCause),
    .excTval (excTval),
    .excPc   (excPc),
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .delegHit(delegHit),
    .redirPc (redirPc),
    .mEpc    (mEpc),
    .mCause  (mCause),
    .mTval   (mTval),
    .sEpc    (sEpc),
    .sCause  (sCause),
    .sTval   (sTval)
  );

  assign curPriv = privQ;

  p_one_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.saveM, strobe.saveS}));
  p_redir_align_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> redirPc[1:0] == 2'b00);
  p_super_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.saveS |=> curPriv == 2'b01);

endmodule

// File: tb/test_trap_entry.sv
`timescale 1ns/1ps
module test_trap_entry;

  localparam int XLEN = 32;
  localparam int CW   = 5;

  logic            clk = 1'b0;
  logic            rstN;
  logic            excValid;
  logic [CW-1:0]   excCause;
  logic [XLEN-1:0] excTval, excPc;
  logic            cfgWrEn;
  logic [1:0]      cfgSel;
  logic [XLEN-1:0] cfgData;
  logic            privWrEn;
  logic [1:0]      privWrData;
  logic [1:0]      curPriv;
  logic            redirValid;
  logic [XLEN-1:0] redirPc, mEpc, mCause, mTval, sEpc, sCause, sTval;

  always #4 clk = ~clk;

  trap_entry #(.XLEN(XLEN), .CAUSE_W(CW)) i_trap_entry (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCause(excCause),
    .excTval(excTval), .excPc(excPc), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .privWrEn(privWrEn), .privWrData(privWrData),
    .curPriv(curPriv), .redirValid(redirValid), .redirPc(redirPc),
    .mEpc(mEpc), .mCause(mCause), .mTval(mTval),
    .sEpc(sEpc), .sCause(sCause), .sTval(sTval)
  );

  typedef struct {
    string           tag;
    logic [1:0]      priv;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] me, mc, mt, se, sc, st;
  } expT;

  expT expQ[$];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [1:0]      mPriv;
  logic [31:0]     mDeleg;
  logic [XLEN-1:0] mMtvec, mStvec;
  logic [XLEN-1:0] rMe, rMc, rMt, rSe, rSc, rSt;

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per redirect pulse
  always @(negedge clk) begin
    if (rstN === 1'b1 && redirValid === 1'b1) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: actual unexpected redirect expected none");
      end else begin
        expT e;
        e = expQ.pop_front();
        chk({e.tag, " priv"},   XLEN'(curPriv), XLEN'(e.priv));
        chk("R8 redirPc",       redirPc, e.pc);
        chk("R5 mEpc",          mEpc,   e.me);
        chk("R7 mCause",        mCause, e.mc);
        chk("R6 mTval",         mTval,  e.mt);
        chk("R5 sEpc",          sEpc,   e.se);
        chk("R7 sCause",        sCause, e.sc);
        chk("R6 sTval",         sTval,  e.st);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    excValid = 0; cfgWrEn = 0; privWrEn = 0;
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [XLEN-1:0] d);
    @(negedge clk);
    excValid = 0; privWrEn = 0;
    cfgWrEn = 1; cfgSel = sel; cfgData = d;
    case (sel)
      2'd0: mDeleg = d;
      2'd1: mMtvec = d;
      2'd2: mStvec = d;
      default: ;
    endcase
  endtask

  task automatic privWrite(logic [1:0] p);
    @(negedge clk);
    excValid = 0; cfgWrEn = 0;
    privWrEn = 1; privWrData = p;
    if (p != 2'b10) mPriv = p;
  endtask

  // drives one exception cycle; inputs stay set until the next task call
  task automatic doExc(string tag, logic [CW-1:0] c, logic [XLEN-1:0] tv,
                       logic [XLEN-1:0] pc, bit withPriv, logic [1:0] pw);
    expT e;
    bit  toS;
    @(negedge clk);
    cfgWrEn = 0;
    excValid = 1; excCause = c; excTval = tv; excPc = pc;
    privWrEn = withPriv; privWrData = pw;
    toS = mDeleg[c] && (mPriv != 2'b11);
    if (toS) begin
      rSe = pc; rSc = XLEN'(c); rSt = tv; mPriv = 2'b01;
      e.pc = {mStvec[XLEN-1:2], 2'b00};
    end else begin
      rMe = pc; rMc = XLEN'(c); rMt = tv; mPriv = 2'b11;
      e.pc = {mMtvec[XLEN-1:2], 2'b00};
    end
    e.tag = tag; e.priv = mPriv;
    e.me = rMe; e.mc = rMc; e.mt = rMt; e.se = rSe; e.sc = rSc; e.st = rSt;
    expQ.push_back(e);
  endtask

  // exception together with a supervisor base write (R11)
  task automatic excWithStvecWrite(logic [CW-1:0] c, logic [XLEN-1:0] pc,
                                   logic [XLEN-1:0] newBase);
    doExc("R11", c, 32'h0, pc, 0, 2'b00);
    cfgWrEn = 1; cfgSel = 2'd2; cfgData = newBase;
    mStvec = newBase;
  endtask

  initial begin
    rstN = 0; excValid = 0; excCause = '0; excTval = '0; excPc = '0;
    cfgWrEn = 0; cfgSel = '0; cfgData = '0; privWrEn = 0; privWrData = '0;
    mPriv = 2'b11; mDeleg = '0; mMtvec = '0; mStvec = '0;
    rMe = '0; rMc = '0; rMt = '0; rSe = '0; rSc = '0; rSt = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 curPriv", XLEN'(curPriv), 32'd3);
    chk("R1 redirValid", XLEN'(redirValid), 32'd0);
    chk("R1 mEpc", mEpc, 0);   chk("R1 mCause", mCause, 0);
    chk("R1 mTval", mTval, 0); chk("R1 sEpc", sEpc, 0);
    chk("R1 sCause", sCause, 0); chk("R1 sTval", sTval, 0);

    // R1: bases reset to zero, so first trap redirects to 0
    doExc("R4", 5'd5, 32'h8000_0000, 32'h0000_1000, 0, 2'b00);
    idle();

    // R9: configuration
    cfgWrite(2'd1, 32'h8000_0103);
    cfgWrite(2'd2, 32'h4000_0206);
    cfgWrite(2'd0, (32'h1 << 5) | (32'h1 << 13));
    idle();

    // R4: delegated cause in machine mode stays in machine mode
    doExc("R4", 5'd5, 32'h8000_0040, 32'h0000_2000, 0, 2'b00);
    idle();

    // R10: privilege write to user
    privWrite(2'b00);
    idle();
    chk("R10 priv write user", XLEN'(curPriv), 32'd0);

    // R2: non-delegated cause from user goes to machine
    doExc("R2", 5'd2, 32'hDEAD_0002, 32'h0000_3000, 0, 2'b00);
    idle();

    // R3: delegated cause from user goes to supervisor
    privWrite(2'b00);
    doExc("R3", 5'd13, 32'h0BAD_000D, 32'h0000_4000, 0, 2'b00);
    // back to back: delegated from supervisor, then non-delegated
    doExc("R3", 5'd5, 32'h9000_0000, 32'h0000_4004, 0, 2'b00);
    doExc("R2", 5'd2, 32'h1111_2222, 32'h0000_4008, 0, 2'b00);
    idle();
    @(negedge clk);
    chk("R8 redirValid low after idle", XLEN'(redirValid), 32'd0);

    // R10: reserved code ignored
    privWrite(2'b10);
    idle();
    chk("R10 reserved priv ignored", XLEN'(curPriv), 32'd3);

    // R10: exception overrides simultaneous privilege write
    doExc("R10", 5'd13, 32'h0000_0077, 32'h0000_5000, 1, 2'b00);
    idle();
    @(negedge clk);
    chk("R10 priv after collision", XLEN'(curPriv), 32'd3);

    // R11: same-cycle base write uses old base, later trap uses new one
    privWrite(2'b00);
    excWithStvecWrite(5'd13, 32'h0000_6000, 32'h1234_567B);
    doExc("R11", 5'd13, 32'h0000_0099, 32'h0000_6004, 0, 2'b00);
    idle();
    repeat (3) @(negedge clk);

    chk("R8 all redirects seen", expQ.size(), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule